// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block models a byte-wide serial EEPROM that answers on a two-wire bus as a slave. Both bus lines are brought into a faster system clock through synchronisers, and start, stop and clock edges are found by comparing each line's synchronised value with its value one system clock earlier. The slave never drives SDA high. It only pulls the line low through the `sdaDrvLow` enable, and the pad or the bench forms the wired-AND with the master.

The array holds 256 bytes in 32 pages of 8 bytes. A master can do byte and page writes, current address reads, random reads and sequential reads. Bytes written in one sequence are collected in a page buffer. At the stop they are committed together, unless the write-protect input is high. After each commit a busy counter, counted in system clocks, stands in for the self-timed write cycle. While that counter runs the slave acknowledges no device address, so a master can poll the slave with acknowledge requests.

Top module: `twoWireEeprom`

## Requirements
- R1: After reset, and whenever the slave is neither acknowledging nor sending a read data bit, `sdaDrvLow` is 0.
- R2: The first byte after a start is compared with 1010, then `strapIn[2:0]`, then the read/write bit (1 = read). On a match the slave pulls SDA low for the ninth clock. On a mismatch it acknowledges nothing until the next start.
- R3: In a write, the second byte is the word address and every later byte is a data byte. Each of these bytes is acknowledged. A stop places the received data in the array.
- R4: During a write, only the low three bits of the address advance after each data byte. The ninth data byte of a sequence therefore lands at the first byte of the same 8-byte page, and later bytes overwrite earlier ones.
- R5: A stop that commits data starts a write cycle of `BUSY_CLKS` system clocks. During that cycle no device address is acknowledged. Once it ends, device addresses are acknowledged again.
- R6: The address counter holds the last accessed address plus one. A read that is not preceded by a word address returns the byte at that counter.
- R7: While the master acknowledges a read byte, the slave sends the next byte. After a master not-acknowledge the slave releases SDA and waits for a stop or a start.
- R8: During reads the counter wraps from address 255 to address 0.
- R9: When `wpIn` is high at the stop, the write is still acknowledged, the array is left unchanged and no write cycle starts.
- R10: A new start before any stop discards the bytes of an unfinished write. No array byte changes and no write cycle starts.
- R11: Read data goes out MSB first. The SDA drive changes only after a falling SCL, or at a start or a stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad (wired-AND value) |
| wpIn | input | 1 | Write protect, high blocks array updates |
| strapIn | input | 3 | Hard-wired device select bits compared with the device address |
| sdaDrvLow | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
A corrupted bit counter or a wrong controller state appears on the bus within one byte. It shows as an acknowledge in the wrong clock, a missing acknowledge, or a read byte shifted by one bit. A fault in the address counter or the page buffer stays hidden until a later read returns a byte from the wrong location, so the bench always reads back what it has written. Those reads cover page wrap, array wrap and the current address. A busy counter that is too long or too short only shows up when the master polls, so the bench polls the slave once right after a commit and once after the write cycle has ended.

// File: rtl/eePkg.sv
package eePkg;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic              setAddr;
    logic              pushData;
    logic              rdLoad;
    logic              commit;
    logic              discard;
    logic [BYTE_W-1:0] byteVal;
  } eeStrobe_t;

  typedef enum logic [2:0] {
    S_IDLE, S_DEV, S_ACK, S_WADDR, S_WDATA, S_RD, S_RACK
  } eeState_t;
endpackage

// File: rtl/eeLineSync.sv
module eeLineSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaQ,
  output logic sclRise,
  output logic sclFall,
  output logic startEv,
  output logic stopEv
);
  logic [1:0] rawLines;
  logic [1:0] synced;
  logic [1:0] prevLines;
  logic       sclQ;

  assign rawLines = {sclIn, sdaIn};

  genvar g;
  generate
    for (g = 0; g < 2; g++) begin : gLine
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '1;
        else       chain <= {chain[STAGES-2:0], rawLines[g]};
      end
      assign synced[g] = chain[STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLines <= 2'b11;
    else       prevLines <= synced;
  end

  assign sclQ    = synced[1];
  assign sdaQ    = synced[0];
  assign sclRise = sclQ && !prevLines[1];
  assign sclFall = !sclQ && prevLines[1];
  assign startEv = sclQ && prevLines[1] && prevLines[0] && !sdaQ;
  assign stopEv  = sclQ && prevLines[1] && !prevLines[0] && sdaQ;
endmodule

// File: rtl/eeCtrl.sv
module eeCtrl
  import eePkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sdaQ,
  input  logic              sclRise,
  input  logic              sclFall,
  input  logic              startEv,
  input  logic              stopEv,
  input  logic [2:0]        strapIn,
  input  logic              busy,
  input  logic [BYTE_W-1:0] rdData,
  output logic              sdaDrv,
  output eeStrobe_t         stb
);
  eeState_t          state, nextAfterAck;
  logic [2:0]        bitCnt;
  logic [BYTE_W-1:0] rxShift, txShift, rxNext;
  logic              ackDrv, ackOn, mAck, isWrite;

  assign rxNext = {rxShift[BYTE_W-2:0], sdaQ};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state        <= S_IDLE;
      nextAfterAck <= S_IDLE;
      bitCnt       <= '0;
      rxShift      <= '0;
      txShift      <= '0;
      ackDrv       <= 1'b0;
      ackOn        <= 1'b0;
      mAck         <= 1'b0;
      isWrite      <= 1'b0;
      sdaDrv       <= 1'b0;
      stb          <= '0;
    end else begin
      stb <= '0;
      if (startEv) begin
        state       <= S_DEV;
        bitCnt      <= '0;
        sdaDrv      <= 1'b0;
        isWrite     <= 1'b0;
        stb.discard <= 1'b1;
      end else if (stopEv) begin
        stb.commit <= isWrite;
        state      <= S_IDLE;
        sdaDrv     <= 1'b0;
        isWrite    <= 1'b0;
      end else begin
        case (state)
          S_DEV, S_WADDR, S_WDATA: if (sclRise) begin
            rxShift <= rxNext;
            bitCnt  <= bitCnt + 3'd1;
            if (bitCnt == 3'd7) begin
              ackOn  <= 1'b0;
              ackDrv <= 1'b1;
              state  <= S_ACK;
              if (state == S_DEV) begin
                if (rxNext[7:1] == {4'b1010, strapIn} && !busy) begin
                  isWrite      <= ~rxNext[0];
                  nextAfterAck <= rxNext[0] ? S_RD : S_WADDR;
                end else begin
                  state <= S_IDLE;
                end
              end else if (state == S_WADDR) begin
                stb.setAddr  <= 1'b1;
                stb.byteVal  <= rxNext;
                nextAfterAck <= S_WDATA;
              end else begin
                stb.pushData <= 1'b1;
                stb.byteVal  <= rxNext;
                nextAfterAck <= S_WDATA;
              end
            end
          end
          S_ACK: if (sclFall) begin
            if (!ackOn) begin
              ackOn  <= 1'b1;
              sdaDrv <= ackDrv;
            end else begin
              ackOn  <= 1'b0;
              state  <= nextAfterAck;
              bitCnt <= '0;
              sdaDrv <= 1'b0;
              if (nextAfterAck == S_RD) begin
                txShift    <= {rdData[BYTE_W-2:0], 1'b0};
                sdaDrv     <= ~rdData[BYTE_W-1];
                stb.rdLoad <= 1'b1;
                bitCnt     <= 3'd1;
              end
            end
          end
          S_RD: if (sclFall) begin
            if (bitCnt == 3'd0) begin
              sdaDrv <= 1'b0;
              state  <= S_RACK;
            end else begin
              sdaDrv  <= ~txShift[BYTE_W-1];
              txShift <= {txShift[BYTE_W-2:0], 1'b0};
              bitCnt  <= bitCnt + 3'd1;
            end
          end
          S_RACK: begin
            if (sclRise) mAck <= ~sdaQ;
            if (sclFall) begin
              if (mAck) begin
                txShift    <= {rdData[BYTE_W-2:0], 1'b0};
                sdaDrv     <= ~rdData[BYTE_W-1];
                stb.rdLoad <= 1'b1;
                bitCnt     <= 3'd1;
                state      <= S_RD;
              end else begin
                sdaDrv <= 1'b0;
                state  <= S_IDLE;
              end
            end
          end
          default: sdaDrv <= 1'b0;
        endcase
      end
    end
  end

  // R11: drive may move only on a falling SCL, a start or a stop
  assert_drive_on_fall_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!sclFall && !startEv && !stopEv) |=> $stable(sdaDrv));

  // R5: the acknowledge slot after a device address is never entered while busy
  assert_no_ack_busy_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($past(state) == S_DEV && state == S_ACK) |-> !$past(busy));

  // R1: in idle the line is released
  assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && $past(state) == S_IDLE) |-> !sdaDrv);
endmodule

// File: rtl/eeDatapath.sv
module eeDatapath
  import eePkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int PAGE_W    = 3,
  parameter int BUSY_CLKS = 1250000
) (
  input  logic              clk,
  input  logic              rstN,
  input  eeStrobe_t         stb,
  input  logic              wpIn,
  output logic              busy,
  output logic [BYTE_W-1:0] rdData
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int PAGE   = 1 << PAGE_W;
  localparam int BUSY_W = $clog2(BUSY_CLKS + 1);

  logic [BYTE_W-1:0] memArr  [DEPTH];
  logic [BYTE_W-1:0] pageBuf [PAGE];
  logic [PAGE-1:0]   pageMask;
  logic [ADDR_W-1:0] addrCnt;
  logic [BUSY_W-1:0] busyCnt;
  logic [PAGE_W-1:0] lane;

  assign lane   = addrCnt[PAGE_W-1:0];
  assign busy   = busyCnt != '0;
  assign rdData = memArr[addrCnt];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) memArr[i] <= '1;
      for (int i = 0; i < PAGE; i++) pageBuf[i] <= '0;
      pageMask <= '0;
      addrCnt  <= '0;
      busyCnt  <= '0;
    end else begin
      if (busy) busyCnt <= busyCnt - 1'b1;
      if (stb.setAddr) addrCnt <= stb.byteVal[ADDR_W-1:0];
      if (stb.pushData) begin
        pageBuf[lane]  <= stb.byteVal;
        pageMask[lane] <= 1'b1;
        addrCnt        <= {addrCnt[ADDR_W-1:PAGE_W], lane + 1'b1};
      end
      if (stb.rdLoad) addrCnt <= addrCnt + 1'b1;
      if (stb.discard) pageMask <= '0;
      if (stb.commit) begin
        if (pageMask != '0 && !wpIn) begin
          for (int i = 0; i < PAGE; i++)
            if (pageMask[i]) memArr[{addrCnt[ADDR_W-1:PAGE_W], PAGE_W'(i)}] <= pageBuf[i];
          busyCnt <= BUSY_W'(BUSY_CLKS);
        end
        pageMask <= '0;
      end
    end
  end

  // R4: a data byte never moves the page part of the address
  assert_page_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    stb.pushData |=> addrCnt[ADDR_W-1:PAGE_W] == $past(addrCnt[ADDR_W-1:PAGE_W]));

  // R8: a read from the last byte continues at byte 0
  assert_read_wrap_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdLoad && addrCnt == '1) |=> addrCnt == '0);

  // R5: no commit arrives while a write cycle runs
  assert_commit_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    stb.commit |-> !busy);

  // R9: a protected commit starts no write cycle
  assert_wp_no_cycle_R9: assert property (@(posedge clk) disable iff (!rstN)
    (stb.commit && wpIn) |=> !busy);
endmodule

// File: rtl/twoWireEeprom.sv
module twoWireEeprom
  import eePkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int PAGE_W      = 3,
  parameter int BUSY_CLKS   = 1250000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic       wpIn,
  input  logic [2:0] strapIn,
  output logic       sdaDrvLow
);
  logic              sdaQ, sclRise, sclFall, startEv, stopEv, busy;
  logic [BYTE_W-1:0] rdData;
  eeStrobe_t         stb;

  eeLineSync #(.STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .sdaQ(sdaQ),
    .sclRise(sclRise), .sclFall(sclFall), .startEv(startEv), .stopEv(stopEv)
  );

  eeCtrl uCtrl (
    .clk(clk), .rstN(rstN), .sdaQ(sdaQ), .sclRise(sclRise), .sclFall(sclFall),
    .startEv(startEv), .stopEv(stopEv), .strapIn(strapIn), .busy(busy),
    .rdData(rdData), .sdaDrv(sdaDrvLow), .stb(stb)
  );

  eeDatapath #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .BUSY_CLKS(BUSY_CLKS)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .wpIn(wpIn), .busy(busy), .rdData(rdData)
  );
endmodule

// File: tb/twoWireEeprom_test.sv
module twoWireEeprom_test;
  localparam int PH = 8;
  localparam int BUSY = 300;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] DEV_W = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] DEV_R = {4'b1010, STRAP, 1'b1};
  // {word address, data}
  localparam logic [15:0] VEC [4] = '{16'h003C, 16'h57A5, 16'hFF01, 16'h807E};

  logic clk = 1'b0, rstN = 1'b0, scl = 1'b1, sdaM = 1'b1, wp = 1'b0;
  logic sdaDrvLow;
  wire  sdaLine = sdaM & ~sdaDrvLow;
  int   checks = 0, failures = 0;

  twoWireEeprom #(.BUSY_CLKS(BUSY)) uut (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaLine), .wpIn(wp),
    .strapIn(STRAP), .sdaDrvLow(sdaDrvLow)
  );

  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic ph;
    repeat (PH) @(negedge clk);
  endtask

  task automatic busStart;
    sdaM = 1'b1; ph; scl = 1'b1; ph; sdaM = 1'b0; ph; scl = 1'b0; ph;
  endtask

  task automatic busStop;
    sdaM = 1'b0; ph; scl = 1'b1; ph; sdaM = 1'b1; ph;
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ackd);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; ph; scl = 1'b1; ph; scl = 1'b0; ph;
    end
    sdaM = 1'b1; ph; scl = 1'b1; ph;
    ackd = !sdaLine;
    scl = 1'b0; ph;
  endtask

  task automatic getByte(input logic masterAck, output logic [7:0] b);
    sdaM = 1'b1;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      ph; scl = 1'b1; ph;
      b = {b[6:0], sdaLine};
      scl = 1'b0;
    end
    sdaM = ~masterAck; ph; scl = 1'b1; ph; scl = 1'b0; ph; sdaM = 1'b1;
  endtask

  task automatic byteWrite(input logic [7:0] a, input logic [7:0] d, output int acks);
    logic k;
    acks = 0;
    busStart;
    sendByte(DEV_W, k); acks += int'(k);
    sendByte(a, k);     acks += int'(k);
    sendByte(d, k);     acks += int'(k);
    busStop;
  endtask

  task automatic randRead(input logic [7:0] a, output logic [7:0] d);
    logic k;
    busStart; sendByte(DEV_W, k); sendByte(a, k);
    busStart; sendByte(DEV_R, k); getByte(1'b0, d); busStop;
  endtask

  task automatic finishRun;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=hung expected=done");
    finishRun;
  end

  initial begin
    logic [7:0] d;
    logic k, k2;
    int acks;
    logic [7:0] pageExp [8];

    repeat (5) @(negedge clk);
    chk("R1 released in reset", {7'd0, sdaDrvLow}, 8'h00);
    rstN = 1'b1;
    repeat (20) @(negedge clk);
    chk("R1 released after reset", {7'd0, sdaDrvLow}, 8'h00);

    // R2: wrong straps, then wrong type code, then a match
    busStart; sendByte({4'b1010, 3'b001, 1'b0}, k); sendByte(8'h00, k2); busStop;
    chk("R2 strap mismatch nack", {7'd0, k}, 8'h00);
    chk("R2 no ack after mismatch", {7'd0, k2}, 8'h00);
    busStart; sendByte({4'b1011, STRAP, 1'b0}, k); busStop;
    chk("R2 type mismatch nack", {7'd0, k}, 8'h00);
    busStart; sendByte(DEV_W, k); busStop;
    chk("R2 match ack", {7'd0, k}, 8'h01);

    // R3: table of byte writes, each read back at random
    foreach (VEC[i]) begin
      byteWrite(VEC[i][15:8], VEC[i][7:0], acks);
      chk("R3 write acks", 8'(acks), 8'd3);
      repeat (BUSY + 100) @(negedge clk);
      randRead(VEC[i][15:8], d);
      chk("R3 readback", d, VEC[i][7:0]);
    end

    // R5: polling during and after the write cycle
    byteWrite(8'h20, 8'h42, acks);
    busStart; sendByte(DEV_W, k); busStop;
    chk("R5 nack while busy", {7'd0, k}, 8'h00);
    repeat (BUSY + 100) @(negedge clk);
    busStart; sendByte(DEV_W, k); busStop;
    chk("R5 ack after cycle", {7'd0, k}, 8'h01);
    randRead(8'h20, d);
    chk("R5 data committed", d, 8'h42);

    // R6: current address read after a write
    byteWrite(8'h41, 8'h66, acks);
    repeat (BUSY + 100) @(negedge clk);
    byteWrite(8'h40, 8'h5A, acks);
    repeat (BUSY + 100) @(negedge clk);
    busStart; sendByte(DEV_R, k); getByte(1'b0, d); busStop;
    chk("R6 current address after write", d, 8'h66);

    // R4: ten bytes from 0x15 wrap inside page 0x10..0x17
    busStart; sendByte(DEV_W, k); sendByte(8'h15, k);
    for (int i = 0; i < 10; i++) sendByte(8'hD0 + 8'(i), k);
    busStop;
    repeat (BUSY + 100) @(negedge clk);
    pageExp = '{8'hD3, 8'hD4, 8'hD5, 8'hD6, 8'hD7, 8'hD8, 8'hD9, 8'hD2};
    busStart; sendByte(DEV_W, k); sendByte(8'h10, k);
    busStart; sendByte(DEV_R, k);
    for (int i = 0; i < 8; i++) begin
      getByte(i < 7, d);
      chk("R4 R7 page wrap sequential", d, pageExp[i]);
    end
    chk("R7 released after nack", {7'd0, sdaDrvLow}, 8'h00);
    busStop;
    busStart; sendByte(DEV_R, k); getByte(1'b0, d); busStop;
    chk("R6 counter after sequential", d, 8'hFF);

    // R8: read wrap from 0xFF to 0x00
    busStart; sendByte(DEV_W, k); sendByte(8'hFF, k);
    busStart; sendByte(DEV_R, k);
    getByte(1'b1, d); chk("R8 last byte", d, 8'h01);
    getByte(1'b0, d); chk("R8 wrapped to 0", d, 8'h3C);
    busStop;

    // R9: protected write acked, array and busy untouched
    wp = 1'b1;
    byteWrite(8'h57, 8'h11, acks);
    chk("R9 protected acks", 8'(acks), 8'd3);
    busStart; sendByte(DEV_R, k); getByte(1'b0, d); busStop;
    chk("R9 no write cycle", {7'd0, k}, 8'h01);
    wp = 1'b0;
    randRead(8'h57, d);
    chk("R9 array unchanged", d, 8'hA5);

    // R10: repeated start aborts the write
    busStart; sendByte(DEV_W, k); sendByte(8'h80, k); sendByte(8'h99, k);
    busStart; sendByte(DEV_R, k); getByte(1'b0, d); busStop;
    chk("R10 ack no busy", {7'd0, k}, 8'h01);
    chk("R10 counter after abort", d, 8'hFF);
    randRead(8'h80, d);
    chk("R10 data discarded", d, 8'h7E);

    // R11: data bit stays put while SCL is high
    busStart; sendByte(DEV_W, k); sendByte(8'h00, k);
    busStart; sendByte(DEV_R, k);
    ph; scl = 1'b1; ph;
    k = sdaLine; ph; k2 = sdaLine;
    chk("R11 MSB first held high", {6'd0, k, k2}, 8'h00);
    scl = 1'b0; ph;
    for (int i = 0; i < 7; i++) begin ph; scl = 1'b1; ph; scl = 1'b0; end
    sdaM = 1'b1; ph; scl = 1'b1; ph; scl = 1'b0; ph;
    busStop;
    chk("R1 released at end", {7'd0, sdaDrvLow}, 8'h00);

    finishRun;
  end
endmodule